// File: doc/BRIEF.md
# Double-Buffered Serial Shift Port with Split Interrupt Requests

This block is a synchronous serial shift port with one staging register on each side. Software writes a byte into a transmit holding register. When the transmit shifter is idle, the byte moves into the shifter and goes out least significant bit first, one bit on each rising edge of the serial clock. The receive side shifts in one bit on each rising serial clock edge. After a full word it copies the word into a receive holding register that software reads.

There are two latched interrupt requests, one for transmit and one for receive, each gated by its own enable bit. A control bit picks the event that raises the transmit request: either the holding register emptying into the shifter, or the shifter finishing a word. Turning the transmitter on puts both of these conditions in the true state at once, so the transmit request latches immediately. Software is expected to turn on the transmitter, clear the latched request, and only then set the transmit interrupt enable.

The register port and the serial pins have no back-pressure. A write to the transmit holding register while it is still full replaces the waiting byte. A word that completes while the receive holding register is still full is dropped and flagged as an overrun. The serial clock input is sampled by the system clock, and only its rising edges are used.

Top module: `sio_dbuf_port`

## Requirements
- R1: After reset, control, status, enable registers and both requests read 0. The serial output is 1 and both interrupt pins are low.
- R2: Setting control bit 0 (transmit on) makes status bit 0 (holding empty) and status bit 1 (shift done) read 1, and latches the transmit request (status bit 4) in either timing mode.
- R3: A byte written to address 0 with the transmitter on and the shifter idle moves into the shifter on the next clock, and status bit 0 returns to 1. The serial output then presents the byte LSB first and advances one bit per rising serial clock edge. It reads 1 when idle.
- R4: With control bit 3 at 0, the transmit request latches when the holding register empties into the shifter.
- R5: With control bit 3 at 1, the transmit request latches when the shifter finishes its eighth edge. It stays clear while shifting.
- R6: With control bit 1 (receive on) set, eight rising edges assemble an LSB-first word. The word is copied to the receive holding register (read at address 0), status bit 2 (receive full) is set and the receive request (status bit 5) latches.
- R7: A read of address 0 clears status bit 2.
- R8: A word that completes while status bit 2 is set sets status bit 3 (overrun), and the held word is kept.
- R9: Writing 1 to status bits 3, 4 or 5 at address 2 clears that flag, unless its setting event happens in the same cycle. The interrupt pins are the latched requests ANDed with address 3 bit 0 (transmit) and bit 1 (receive).
- R10: A byte written while the shifter is busy waits with status bit 0 at 0. It moves into the shifter once the current word is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 0) |
| reg_addr | input | 2 | 0 data, 1 control, 2 status, 3 interrupt enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| ser_clk | input | 1 | Serial clock, rising edges shift |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench builds the port with its default eight-bit word, with the serial output looped back to the input. At that width every byte value fits in a full sweep. All 256 values are sent and received in both transmit timing modes. For each value the bench checks the bit order on the line, the moment the transmit request appears and the received word. The small word also keeps the enable-sequence, overrun and back-to-back cases short enough to run as directed sequences.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    ADR_DATA = 2'd0,
    ADR_CTRL = 2'd1,
    ADR_STAT = 2'd2,
    ADR_IEN  = 2'd3
  } sio_addr_e;

  localparam int CTL_TX_ON  = 0;
  localparam int CTL_RX_ON  = 1;
  localparam int CTL_TX_SEL = 3;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVR   = 3;
  localparam int ST_TXREQ = 4;
  localparam int ST_RXREQ = 5;

  localparam int IEN_TX = 0;
  localparam int IEN_RX = 1;
endpackage

// File: rtl/sio_tx_path.sv
module sio_tx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ser_edge,
  output logic              buf_empty,
  output logic              shift_done,
  output logic              sdo
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              busy_q;
  logic              on_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= '0;
      sh_q       <= '0;
      left_q     <= '0;
      busy_q     <= 1'b0;
      on_q       <= 1'b0;
      buf_empty  <= 1'b0;
      shift_done <= 1'b0;
    end else begin
      on_q <= tx_on;
      if (!tx_on) begin
        buf_empty  <= 1'b0;
        shift_done <= 1'b0;
        busy_q     <= 1'b0;
        left_q     <= '0;
      end else if (!on_q) begin
        buf_empty  <= 1'b1;
        shift_done <= 1'b1;
      end else begin
        if (busy_q) begin
          if (ser_edge) begin
            sh_q   <= {1'b1, sh_q[DATA_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              busy_q     <= 1'b0;
              shift_done <= 1'b1;
            end
          end
        end else if (!buf_empty) begin
          sh_q       <= hold_q;
          left_q     <= CNT_W'(DATA_W);
          busy_q     <= 1'b1;
          shift_done <= 1'b0;
          buf_empty  <= 1'b1;
        end
        if (load) begin
          hold_q    <= load_data;
          buf_empty <= 1'b0;
        end
      end
    end
  end

  assign sdo = busy_q ? sh_q[0] : 1'b1;

  a_r2_enable_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_on) |=> (buf_empty && shift_done));

  a_r5_done_after_last_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ser_edge && left_q == CNT_W'(1) && tx_on && on_q) |=> shift_done);

  a_r10_waits_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !buf_empty && tx_on) |=> !buf_empty);

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(DATA_W));
endmodule

// File: rtl/sio_rx_path.sv
module sio_rx_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              sdi,
  input  logic              ser_edge,
  input  logic              pop,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              word_done
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-2:0] sh_q;
  logic [CNT_W-1:0]  got_q;
  logic [DATA_W-1:0] next_w;

  assign next_w    = {sdi, sh_q};
  assign word_done = rx_on && ser_edge && (got_q == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      got_q   <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (!rx_on) begin
        got_q <= '0;
      end else if (ser_edge) begin
        sh_q  <= next_w[DATA_W-1:1];
        got_q <= word_done ? '0 : got_q + 1'b1;
      end
      if (ovr_clr) overrun <= 1'b0;
      if (word_done) begin
        if (rx_full && !pop) begin
          overrun <= 1'b1;
        end else begin
          rx_data <= next_w;
        end
        rx_full <= 1'b1;
      end else if (pop) begin
        rx_full <= 1'b0;
      end
    end
  end

  a_r8_keep_old_word: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_full && !pop) |=> ($stable(rx_data) && overrun));

  a_r7_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !word_done) |=> !rx_full);

  a_r6_word_fills_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_full);
endmodule

// File: rtl/sio_req_latch.sv
module sio_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_done,
  input  logic buf_empty,
  input  logic shift_done,
  input  logic rx_word,
  input  logic clr_tx,
  input  logic clr_rx,
  input  logic ien_tx,
  input  logic ien_rx,
  output logic tx_req,
  output logic rx_req,
  output logic irq_tx,
  output logic irq_rx
);
  logic empty_q;
  logic done_q;
  logic tx_evt;

  assign tx_evt = sel_done ? (shift_done && !done_q) : (buf_empty && !empty_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= 1'b0;
      done_q  <= 1'b0;
      tx_req  <= 1'b0;
      rx_req  <= 1'b0;
    end else begin
      empty_q <= buf_empty;
      done_q  <= shift_done;
      if (tx_evt)      tx_req <= 1'b1;
      else if (clr_tx) tx_req <= 1'b0;
      if (rx_word)     rx_req <= 1'b1;
      else if (clr_rx) rx_req <= 1'b0;
    end
  end

  assign irq_tx = tx_req && ien_tx;
  assign irq_rx = rx_req && ien_rx;

  a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tx && !tx_evt) |=> !tx_req);

  a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rx && !rx_word) |=> !rx_req);

  a_r4_empty_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_done && $rose(buf_empty)) |=> tx_req);

  a_r5_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_done && $rose(shift_done)) |=> tx_req);
endmodule

// File: rtl/sio_dbuf_port.sv
module sio_dbuf_port #(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       ser_clk,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       irq_tx,
  output logic       irq_rx
);
  import sio_pkg::*;

  sio_addr_e         adr;
  logic [7:0]        ctrl_q;
  logic [7:0]        ien_q;
  logic              sclk_q;
  logic              ser_edge;
  logic              buf_empty;
  logic              shift_done;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full;
  logic              overrun;
  logic              word_done;
  logic              tx_req;
  logic              rx_req;
  logic              wr_data;
  logic              wr_stat;
  logic              pop;
  logic [7:0]        status;

  assign adr      = sio_addr_e'(reg_addr);
  assign wr_data  = reg_wr && (adr == ADR_DATA);
  assign wr_stat  = reg_wr && (adr == ADR_STAT);
  assign pop      = reg_rd && (adr == ADR_DATA);
  assign ser_edge = ser_clk && !sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= ser_clk;
      if (reg_wr && adr == ADR_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && adr == ADR_IEN)  ien_q  <= reg_wdata;
    end
  end

  sio_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_on     (ctrl_q[CTL_TX_ON]),
    .load      (wr_data),
    .load_data (reg_wdata[DATA_W-1:0]),
    .ser_edge  (ser_edge),
    .buf_empty (buf_empty),
    .shift_done(shift_done),
    .sdo       (ser_dout)
  );

  sio_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_on    (ctrl_q[CTL_RX_ON]),
    .sdi      (ser_din),
    .ser_edge (ser_edge),
    .pop      (pop),
    .ovr_clr  (wr_stat && reg_wdata[ST_OVR]),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .overrun  (overrun),
    .word_done(word_done)
  );

  sio_req_latch u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_done  (ctrl_q[CTL_TX_SEL]),
    .buf_empty (buf_empty),
    .shift_done(shift_done),
    .rx_word   (word_done),
    .clr_tx    (wr_stat && reg_wdata[ST_TXREQ]),
    .clr_rx    (wr_stat && reg_wdata[ST_RXREQ]),
    .ien_tx    (ien_q[IEN_TX]),
    .ien_rx    (ien_q[IEN_RX]),
    .tx_req    (tx_req),
    .rx_req    (rx_req),
    .irq_tx    (irq_tx),
    .irq_rx    (irq_rx)
  );

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = buf_empty;
    status[ST_DONE]  = shift_done;
    status[ST_FULL]  = rx_full;
    status[ST_OVR]   = overrun;
    status[ST_TXREQ] = tx_req;
    status[ST_RXREQ] = rx_req;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (adr)
      ADR_DATA: reg_rdata[DATA_W-1:0] = rx_data;
      ADR_CTRL: reg_rdata = ctrl_q;
      ADR_STAT: reg_rdata = status;
      ADR_IEN:  reg_rdata = ien_q;
      default:  reg_rdata = '0;
    endcase
  end

  a_r1_idle_line_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CTL_TX_ON] && !$past(ctrl_q[CTL_TX_ON])) |=> ser_dout);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx |-> ien_q[IEN_TX]) and (irq_rx |-> ien_q[IEN_RX]));
endmodule

// File: tb/sio_dbuf_port_test.sv
module sio_dbuf_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ser_clk = 1'b0;
  logic       ser_dout;
  logic       irq_tx;
  logic       irq_rx;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         ended = 1'b0;

  always #10 clk = ~clk;

  sio_dbuf_port uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ser_clk(ser_clk), .ser_din(ser_dout), .ser_dout(ser_dout),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] d);
    reg_addr = 2'd0; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // eight rising serial edges; optionally checks LSB-first bit order (R3)
  task automatic shift8(input logic [7:0] b, input bit check);
    for (int i = 0; i < 8; i++) begin
      if (check) chk("R3 sdo bit", ser_dout, b[i]);
      ser_clk = 1'b1; tick(2);
      ser_clk = 1'b0; tick(2);
    end
    tick(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit sel);
    logic [7:0] s;
    logic [7:0] d;
    wr(2'd2, 8'h38);
    wr(2'd0, b);
    tick(2);
    peek(2'd2, s);
    chk("R3 empty after move", s[0], 1);
    chk("R3 shifting", s[1], 0);
    if (!sel) chk("R4 tx irq on empty", irq_tx, 1);
    else      chk("R5 tx irq held while shifting", irq_tx, 0);
    shift8(b, 1'b1);
    peek(2'd2, s);
    chk("R5 shift done", s[1], 1);
    if (sel) chk("R5 tx irq on done", irq_tx, 1);
    chk("R6 rx full", s[2], 1);
    chk("R6 rx irq", irq_rx, 1);
    pop(d);
    chk("R6 rx word", d, b);
    peek(2'd2, s);
    chk("R7 full cleared", s[2], 0);
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    peek(2'd2, s); chk("R1 status", s, 0);
    peek(2'd1, s); chk("R1 control", s, 0);
    peek(2'd3, s); chk("R1 enables", s, 0);
    chk("R1 sdo idle", ser_dout, 1);
    chk("R1 irqs", {irq_tx, irq_rx}, 0);

    // enable sequence: tx on, clear request, then enable interrupts
    wr(2'd1, 8'h03);
    tick(3);
    peek(2'd2, s);
    chk("R2 empty+done", s[1:0], 2'b11);
    chk("R2 request latched", s[4], 1);
    chk("R9 masked irq", irq_tx, 0);
    wr(2'd2, 8'h38);
    peek(2'd2, s);
    chk("R9 request cleared", s[4], 0);
    wr(2'd3, 8'h03);
    chk("R9 irq after enable", irq_tx, 0);
    chk("R3 idle line", ser_dout, 1);

    for (int sel = 0; sel < 2; sel++) begin
      wr(2'd1, 8'h03 | (sel[0] ? 8'h08 : 8'h00));
      tick(2);
      for (int b = 0; b < 256; b++) send_byte(8'(b), sel[0]);
    end

    // overrun with sel=0
    wr(2'd1, 8'h03);
    wr(2'd0, 8'hA5); tick(2); shift8(8'hA5, 1'b0);
    wr(2'd0, 8'h3C); tick(2); shift8(8'h3C, 1'b1);
    peek(2'd2, s);
    chk("R8 overrun set", s[3], 1);
    pop(d);
    chk("R8 old word kept", d, 8'hA5);
    wr(2'd2, 8'h08);
    peek(2'd2, s);
    chk("R9 overrun cleared", s[3], 0);

    // back-to-back writes
    wr(2'd0, 8'h11); tick(2);
    wr(2'd0, 8'h22); tick(1);
    peek(2'd2, s);
    chk("R10 second byte waits", s[0], 0);
    shift8(8'h11, 1'b1);
    peek(2'd2, s);
    chk("R10 second byte moved", s[1:0], 2'b01);
    pop(d);
    chk("R10 first word", d, 8'h11);
    shift8(8'h22, 1'b1);
    pop(d);
    chk("R10 second word", d, 8'h22);
    chk("R3 idle after", ser_dout, 1);

    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule